// File: doc/BRIEF.md
# Texture Coordinate Addressing Unit

This block turns a texture fetch coordinate into texel indices and a linear memory address. A request carries one coordinate per axis in signed fixed point with 8 fractional bits. It also carries the number of active axes (1, 2 or 3) and a set of mode bits. The texture's extent on each axis and its row pitch are quasi-static inputs. They must not change while a request is in flight.

Each active coordinate is read either in texel units or as a normalized value, where 1.0 spans the full extent of its axis. The block takes the floor, then folds the index into range by wrapping (modulo) or clamping (to the nearest edge). In filter mode it also returns the folded next-higher neighbour and the fractional weight, which a downstream filter unit consumes. A raw linear mode treats the texture as a flat 1D buffer: the integer part of the x coordinate becomes the address, with no scaling, folding or filtering. Results leave through a valid/ready port after a fixed two-cycle latency, and the pipeline stalls as a whole under backpressure.

Top module: `tex_addr_unit`

## Requirements
- R1: A request accepted in cycle c (in_valid_i and in_ready_o both high at the edge ending c) is presented on the output in cycle c+2.
- R2: While out_valid_o is high and out_ready_i is low, all outputs hold their values and in_ready_o is low. Results leave in acceptance order.
- R3: dims_i selects the active axes: 2 means x and y, 3 means x, y and z, and 0 or 1 means x only. For an inactive axis, idx0_o, idx1_o and frac_o are all 0, and its coordinate has no effect.
- R4: In unnormalized mode (norm_i=0), the coordinate is in texel units as signed Q.8, and the base index is floor(coord/256).
- R5: In normalized mode (norm_i=1), the texel position is coord*size in Q.8 (256 represents 1.0), and the base index is its floor.
- R6: In wrap mode (wrap_i=1), an index i becomes i mod size, always in 0..size-1, including for negative i.
- R7: In clamp mode (wrap_i=0), a negative index becomes 0 and an index of size or more becomes size-1.
- R8: With filter_i=1, idx1_o is the folded value of floor+1, and frac_o is the low 8 bits of the Q.8 position. With filter_i=0, idx1_o equals idx0_o and frac_o is 0.
- R9: With linear_i=1, addr_o is the sign-extended integer part of the x coordinate. idx0_o and idx1_o of x carry its low bits. No fold, normalization or filtering is applied, and the y and z coordinates and dims_i are ignored.
- R10: Otherwise addr_o = x0 + y0*pitch_i + z0*pitch_i*size_y, using the folded base indices.
- R11: While rst_ni is low, out_valid_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Request accepted when high with in_valid_i |
| coord_i | input | NAX x CW | Per-axis signed Q.8 coordinate, x in the lowest slot |
| dims_i | input | 2 | Number of active axes |
| norm_i | input | 1 | Coordinates are normalized |
| wrap_i | input | 1 | 1 wrap, 0 clamp |
| filter_i | input | 1 | Produce neighbour index and weight |
| linear_i | input | 1 | Raw linear-memory addressing |
| size_i | input | NAX x DIM_W | Texture extent per axis |
| pitch_i | input | DIM_W | Row pitch in texels |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Result accepted |
| addr_o | output | AW | Linear texel address |
| idx0_o | output | NAX x DIM_W | Folded base index per axis |
| idx1_o | output | NAX x DIM_W | Folded neighbour index per axis |
| frac_o | output | NAX x FW | Fractional weight per axis |

## Verification
Assertions check several properties on every cycle:
- Output values hold under backpressure, and a request accepted at the input produces output two cycles later.
- Folded indices stay below the axis size.
- In clamp mode the neighbour index never falls below the base index.
- Inactive axes read as zero.

Only the bench's scenarios can show that the values themselves are right. These include modulo results for negative and exact-size coordinates, normalized scaling, fraction extraction, the pitch-based address, and the raw linear path ignoring the other modes. The bench also checks result ordering across a stall.

// File: rtl/tex_addr_pkg.sv
package tex_addr_pkg;
  typedef struct packed {
    logic wrap;
    logic filter;
    logic linear;
  } tex_mode_t;
endpackage

// File: rtl/tex_axis_scale.sv
module tex_axis_scale #(
  parameter int CW    = 20,
  parameter int FW    = 8,
  parameter int DIM_W = 12,
  localparam int TW   = CW + DIM_W + 1,
  localparam int IW   = TW - FW
) (
  input  logic signed [CW-1:0]    coord_i,
  input  logic        [DIM_W-1:0] size_i,
  input  logic                    norm_i,
  input  logic                    filter_i,
  input  logic                    active_i,
  output logic signed [IW-1:0]    pos_o,
  output logic        [FW-1:0]    frac_o
);
  logic signed [TW-1:0] cx, sx, t;

  always_comb begin
    cx = {{(TW-CW){coord_i[CW-1]}}, coord_i};
    sx = {{(TW-DIM_W){1'b0}}, size_i};
    t  = norm_i ? cx * sx : cx;
    pos_o  = active_i ? t[TW-1:FW] : '0;   // arithmetic floor
    frac_o = (active_i && filter_i) ? t[FW-1:0] : '0;
  end
endmodule

// File: rtl/tex_index_fold.sv
module tex_index_fold #(
  parameter int IW    = 25,
  parameter int DIM_W = 12
) (
  input  logic signed [IW-1:0]    pos_i,
  input  logic        [DIM_W-1:0] size_i,
  input  logic                    wrap_i,
  output logic        [DIM_W-1:0] idx_o
);
  logic signed [IW-1:0] sz, rem, res;

  always_comb begin
    sz  = {{(IW-DIM_W){1'b0}}, size_i};
    rem = '0;
    if (size_i == '0) begin
      res = '0;
    end else if (wrap_i) begin
      rem = pos_i % sz;                 // sign follows dividend
      res = rem[IW-1] ? rem + sz : rem;
    end else if (pos_i[IW-1]) begin
      res = '0;
    end else if (pos_i >= sz) begin
      res = sz - IW'(1);
    end else begin
      res = pos_i;
    end
    idx_o = res[DIM_W-1:0];
  end
endmodule

// File: rtl/tex_lin_addr.sv
module tex_lin_addr #(
  parameter int DIM_W = 12,
  parameter int AW    = 32
) (
  input  logic [DIM_W-1:0] x_i,
  input  logic [DIM_W-1:0] y_i,
  input  logic [DIM_W-1:0] z_i,
  input  logic [DIM_W-1:0] pitch_i,
  input  logic [DIM_W-1:0] height_i,
  output logic [AW-1:0]    addr_o
);
  logic [AW-1:0] xe, ye, ze, pe, he, slice;

  always_comb begin
    xe     = AW'(x_i);
    ye     = AW'(y_i);
    ze     = AW'(z_i);
    pe     = AW'(pitch_i);
    he     = AW'(height_i);
    slice  = pe * he;
    addr_o = xe + ye * pe + ze * slice;
  end
endmodule

// File: rtl/tex_addr_unit.sv
module tex_addr_unit
  import tex_addr_pkg::*;
#(
  parameter int CW    = 20,
  parameter int FW    = 8,
  parameter int DIM_W = 12,
  parameter int AW    = 32,
  parameter int NAX   = 3
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      in_valid_i,
  output logic                      in_ready_o,
  input  logic [NAX-1:0][CW-1:0]    coord_i,
  input  logic [1:0]                dims_i,
  input  logic                      norm_i,
  input  logic                      wrap_i,
  input  logic                      filter_i,
  input  logic                      linear_i,
  input  logic [NAX-1:0][DIM_W-1:0] size_i,
  input  logic [DIM_W-1:0]          pitch_i,
  output logic                      out_valid_o,
  input  logic                      out_ready_i,
  output logic [AW-1:0]             addr_o,
  output logic [NAX-1:0][DIM_W-1:0] idx0_o,
  output logic [NAX-1:0][DIM_W-1:0] idx1_o,
  output logic [NAX-1:0][FW-1:0]    frac_o
);
  localparam int TW = CW + DIM_W + 1;
  localparam int IW = TW - FW;

  logic adv;
  assign adv        = !out_valid_o || out_ready_i;
  assign in_ready_o = adv;

  // stage 1: scale and floor
  logic signed [IW-1:0] pos_n  [NAX];
  logic        [FW-1:0] frac_n [NAX];
  logic        [NAX-1:0] act_n;
  tex_mode_t            mode_n;

  assign mode_n = '{wrap: wrap_i, filter: filter_i && !linear_i, linear: linear_i};

  for (genvar a = 0; a < NAX; a++) begin : g_s1
    assign act_n[a] = (a == 0) || (!linear_i && (dims_i > 2'(a)));
    tex_axis_scale #(.CW(CW), .FW(FW), .DIM_W(DIM_W)) u_scale (
      .coord_i ($signed(coord_i[a])),
      .size_i  (size_i[a]),
      .norm_i  (norm_i && !linear_i),
      .filter_i(mode_n.filter),
      .active_i(act_n[a]),
      .pos_o   (pos_n[a]),
      .frac_o  (frac_n[a])
    );
  end

  logic                 s1_valid;
  logic signed [IW-1:0] s1_pos  [NAX];
  logic        [FW-1:0] s1_frac [NAX];
  logic       [NAX-1:0] s1_act;
  tex_mode_t            s1_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid <= 1'b0;
      s1_act   <= '0;
      s1_mode  <= '0;
      for (int a = 0; a < NAX; a++) begin
        s1_pos[a]  <= '0;
        s1_frac[a] <= '0;
      end
    end else if (adv) begin
      s1_valid <= in_valid_i;
      if (in_valid_i) begin
        s1_act  <= act_n;
        s1_mode <= mode_n;
        for (int a = 0; a < NAX; a++) begin
          s1_pos[a]  <= pos_n[a];
          s1_frac[a] <= frac_n[a];
        end
      end
    end
  end

  // stage 2: fold and address
  logic [NAX-1:0][DIM_W-1:0] idx0_n, idx1_n, fold0, fold1;
  logic [AW-1:0]             grid_addr, addr_n;

  for (genvar a = 0; a < NAX; a++) begin : g_s2
    logic signed [IW-1:0] nxt;
    assign nxt = s1_pos[a] + IW'(1);

    tex_index_fold #(.IW(IW), .DIM_W(DIM_W)) u_fold0 (
      .pos_i(s1_pos[a]), .size_i(size_i[a]), .wrap_i(s1_mode.wrap), .idx_o(fold0[a])
    );
    tex_index_fold #(.IW(IW), .DIM_W(DIM_W)) u_fold1 (
      .pos_i(nxt), .size_i(size_i[a]), .wrap_i(s1_mode.wrap), .idx_o(fold1[a])
    );

    always_comb begin
      if (!s1_act[a]) begin
        idx0_n[a] = '0;
        idx1_n[a] = '0;
      end else if (s1_mode.linear) begin
        idx0_n[a] = s1_pos[a][DIM_W-1:0];
        idx1_n[a] = s1_pos[a][DIM_W-1:0];
      end else begin
        idx0_n[a] = fold0[a];
        idx1_n[a] = s1_mode.filter ? fold1[a] : fold0[a];
      end
    end
  end

  tex_lin_addr #(.DIM_W(DIM_W), .AW(AW)) u_lin (
    .x_i(idx0_n[0]), .y_i(idx0_n[1]), .z_i(idx0_n[2]),
    .pitch_i(pitch_i), .height_i(size_i[1]), .addr_o(grid_addr)
  );

  assign addr_n = s1_mode.linear ? AW'(s1_pos[0]) : grid_addr;

  logic     [NAX-1:0] o_act;
  tex_mode_t          o_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      addr_o      <= '0;
      idx0_o      <= '0;
      idx1_o      <= '0;
      frac_o      <= '0;
      o_act       <= '0;
      o_mode      <= '0;
    end else if (adv) begin
      out_valid_o <= s1_valid;
      if (s1_valid) begin
        addr_o <= addr_n;
        idx0_o <= idx0_n;
        idx1_o <= idx1_n;
        for (int a = 0; a < NAX; a++) frac_o[a] <= s1_frac[a];
        o_act  <= s1_act;
        o_mode <= s1_mode;
      end
    end
  end

  // R1
  latency_two_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> ##1 out_valid_o);

  // R2
  stall_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(addr_o)
      && $stable(idx0_o) && $stable(idx1_o) && $stable(frac_o)));

  for (genvar a = 0; a < NAX; a++) begin : g_chk
    // R6
    fold_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && !o_mode.linear && size_i[a] != '0)
        |-> (idx0_o[a] < size_i[a] && idx1_o[a] < size_i[a]));
    // R7
    clamp_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && !o_mode.linear && !o_mode.wrap) |-> (idx1_o[a] >= idx0_o[a]));
    // R3
    idle_axis_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid_o && !o_act[a]) |-> (idx0_o[a] == '0 && idx1_o[a] == '0 && frac_o[a] == '0));
  end
endmodule

// File: tb/tb_tex_addr_unit.sv
module tb_tex_addr_unit;
  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic              in_valid, in_ready, norm, wrap, filt, lin, out_valid, out_ready;
  logic [2:0][19:0]  coord;
  logic [1:0]        dims;
  logic [2:0][11:0]  size, idx0, idx1;
  logic [11:0]       pitch;
  logic [31:0]       addr;
  logic [2:0][7:0]   frac;

  tex_addr_unit dut (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .coord_i(coord), .dims_i(dims), .norm_i(norm), .wrap_i(wrap), .filter_i(filt),
    .linear_i(lin), .size_i(size), .pitch_i(pitch), .out_valid_o(out_valid),
    .out_ready_i(out_ready), .addr_o(addr), .idx0_o(idx0), .idx1_o(idx1), .frac_o(frac)
  );

  typedef struct packed {
    logic [1:0]         dims;
    logic               norm, wrap, filt, lin;
    logic signed [19:0] cx, cy, cz;
    logic [11:0]        a0, b0, c0, a1, b1, c1;
    logic [7:0]         fx, fy, fz;
    logic [31:0]        addr;
  } vec_t;

  localparam int NV = 17;
  // sizes x=10 y=6 z=4, pitch 16; coordinates Q.8
  localparam vec_t VEC [NV] = '{
    '{2'd1,1'b0,1'b0,1'b0,1'b0, 20'sd768,   20'sd0,    20'sd0,   12'd3,12'd0,12'd0, 12'd3,12'd0,12'd0, 8'd0,8'd0,8'd0, 32'd3},
    '{2'd2,1'b0,1'b1,1'b0,1'b0, 20'sd3200, -20'sd256,  20'sd0,   12'd2,12'd5,12'd0, 12'd2,12'd5,12'd0, 8'd0,8'd0,8'd0, 32'd82},
    '{2'd2,1'b0,1'b0,1'b0,1'b0, 20'sd3200, -20'sd256,  20'sd0,   12'd9,12'd0,12'd0, 12'd9,12'd0,12'd0, 8'd0,8'd0,8'd0, 32'd9},
    '{2'd3,1'b0,1'b1,1'b1,1'b0, 20'sd2368,  20'sd1408, 20'sd960, 12'd9,12'd5,12'd3, 12'd0,12'd0,12'd0, 8'd64,8'd128,8'd192, 32'd377},
    '{2'd3,1'b0,1'b0,1'b1,1'b0, 20'sd2368,  20'sd1408, 20'sd960, 12'd9,12'd5,12'd3, 12'd9,12'd5,12'd3, 8'd64,8'd128,8'd192, 32'd377},
    '{2'd2,1'b1,1'b1,1'b1,1'b0, 20'sd128,   20'sd64,   20'sd0,   12'd5,12'd1,12'd0, 12'd6,12'd2,12'd0, 8'd0,8'd128,8'd0, 32'd21},
    '{2'd2,1'b1,1'b0,1'b0,1'b0, 20'sd384,  -20'sd128,  20'sd0,   12'd9,12'd0,12'd0, 12'd9,12'd0,12'd0, 8'd0,8'd0,8'd0, 32'd9},
    '{2'd2,1'b1,1'b1,1'b0,1'b0, 20'sd320,  -20'sd32,   20'sd0,   12'd2,12'd5,12'd0, 12'd2,12'd5,12'd0, 8'd0,8'd0,8'd0, 32'd82},
    '{2'd3,1'b0,1'b1,1'b1,1'b1, 20'sd315904,20'sd1792, 20'sd1792,12'd1234,12'd0,12'd0, 12'd1234,12'd0,12'd0, 8'd0,8'd0,8'd0, 32'd1234},
    '{2'd1,1'b1,1'b0,1'b1,1'b1, 20'sd1472,  20'sd0,    20'sd0,   12'd5,12'd0,12'd0, 12'd5,12'd0,12'd0, 8'd0,8'd0,8'd0, 32'd5},
    '{2'd1,1'b0,1'b0,1'b1,1'b0,-20'sd128,   20'sd0,    20'sd0,   12'd0,12'd0,12'd0, 12'd0,12'd0,12'd0, 8'd128,8'd0,8'd0, 32'd0},
    '{2'd1,1'b0,1'b1,1'b1,1'b0,-20'sd128,   20'sd0,    20'sd0,   12'd9,12'd0,12'd0, 12'd0,12'd0,12'd0, 8'd128,8'd0,8'd0, 32'd9},
    '{2'd1,1'b0,1'b1,1'b0,1'b0,-20'sd5376,  20'sd0,    20'sd0,   12'd9,12'd0,12'd0, 12'd9,12'd0,12'd0, 8'd0,8'd0,8'd0, 32'd9},
    '{2'd2,1'b0,1'b1,1'b0,1'b0, 20'sd256,   20'sd256,  20'sd512, 12'd1,12'd1,12'd0, 12'd1,12'd1,12'd0, 8'd0,8'd0,8'd0, 32'd17},
    '{2'd0,1'b0,1'b0,1'b0,1'b0, 20'sd512,   20'sd256,  20'sd0,   12'd2,12'd0,12'd0, 12'd2,12'd0,12'd0, 8'd0,8'd0,8'd0, 32'd2},
    '{2'd1,1'b0,1'b1,1'b0,1'b0, 20'sd2560,  20'sd0,    20'sd0,   12'd0,12'd0,12'd0, 12'd0,12'd0,12'd0, 8'd0,8'd0,8'd0, 32'd0},
    '{2'd3,1'b1,1'b0,1'b1,1'b0, 20'sd255,   20'sd256,  20'sd128, 12'd9,12'd5,12'd2, 12'd9,12'd5,12'd3, 8'd246,8'd0,8'd0, 32'd281}
  };

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive_1d(input int x);
    dims = 2'd1; norm = 1'b0; wrap = 1'b0; filt = 1'b0; lin = 1'b0;
    coord = {20'sd0, 20'sd0, 20'(x * 256)};
    in_valid = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
    coord = '0; dims = 2'd1; norm = 1'b0; wrap = 1'b0; filt = 1'b0; lin = 1'b0;
    size = {12'd4, 12'd6, 12'd10}; pitch = 12'd16;
    repeat (3) @(negedge clk);
    chk("R11", "out_valid in reset", 64'(out_valid), 64'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) begin
      string t0;
      @(negedge clk);
      dims = VEC[k].dims; norm = VEC[k].norm; wrap = VEC[k].wrap;
      filt = VEC[k].filt; lin = VEC[k].lin;
      coord = {VEC[k].cz, VEC[k].cy, VEC[k].cx};
      in_valid = 1'b1;
      chk("R2", "in_ready idle", 64'(in_ready), 64'd1);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R1", "valid after one cycle", 64'(out_valid), 64'd0);
      @(negedge clk);
      chk("R1", "valid after two cycles", 64'(out_valid), 64'd1);
      t0 = VEC[k].lin ? "R9" : (VEC[k].norm ? "R5" : (VEC[k].wrap ? "R6" : "R4"));
      chk(t0, $sformatf("vec%0d idx0", k), 64'(idx0), 64'({VEC[k].c0, VEC[k].b0, VEC[k].a0}));
      chk(VEC[k].wrap ? "R6" : "R7", $sformatf("vec%0d idx1", k), 64'(idx1),
          64'({VEC[k].c1, VEC[k].b1, VEC[k].a1}));
      chk("R8", $sformatf("vec%0d frac", k), 64'(frac), 64'({VEC[k].fz, VEC[k].fy, VEC[k].fx}));
      chk(VEC[k].lin ? "R9" : "R10", $sformatf("vec%0d addr", k), 64'(addr), 64'(VEC[k].addr));
      if (VEC[k].dims < 2'd2 || VEC[k].lin)
        chk("R3", $sformatf("vec%0d idle y/z", k), 64'({idx0[2], idx0[1], idx1[2], idx1[1]}), 64'd0);
    end

    // R2: stall with three requests, expect hold then in-order drain
    @(negedge clk); out_ready = 1'b0; drive_1d(1);
    @(negedge clk); drive_1d(2);
    @(negedge clk); drive_1d(3);
    chk("R2", "stalled addr", 64'(addr), 64'd1);
    chk("R2", "in_ready stalled", 64'(in_ready), 64'd0);
    repeat (3) @(negedge clk);
    chk("R2", "held addr", 64'(addr), 64'd1);
    chk("R2", "held valid", 64'(out_valid), 64'd1);
    chk("R2", "held in_ready", 64'(in_ready), 64'd0);
    out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    chk("R2", "second result", 64'(addr), 64'd2);
    @(negedge clk);
    chk("R2", "third result", 64'(addr), 64'd3);
    chk("R2", "third valid", 64'(out_valid), 64'd1);
    @(negedge clk);
    chk("R2", "drained", 64'(out_valid), 64'd0);

    // R11: reset mid-stream clears output
    drive_1d(4);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    #1;
    chk("R11", "valid cleared by reset", 64'(out_valid), 64'd0);
    @(negedge clk); rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule